// File: doc/BRIEF.md
# Serial Transmitter with Break and Preamble Generation

This block turns bytes into an asynchronous serial bit stream. Bytes go into a one-entry holding register. They move from there into a shift register, which sends them as frames of a start bit, eight or nine data bits (least significant first) and a stop bit. A bit-rate tick from outside sets the bit timing: each transmitted bit lasts from one tick to the next.

Apart from plain data, the transmitter can send two other kinds of unit. A preamble is one frame-length of marking (logic 1). It is queued each time the enable control goes from 0 to 1. A break is one frame-length of spacing (logic 0), sent while the send-break control is held at 1. When the enable is cleared, the frame already in flight still runs to its end. Only then does the block stop claiming the pin. An output-enable line tells the pin multiplexer when the transmitter owns the pin.

The sequencer has five states: IDLE, PREAMBLE, FRAME, BREAK and MARK. Every unit takes N bit times, where N is 10, or 11 when the frame-length select is 1. The only exception is MARK, which takes one bit time. While the bit counter is non-zero, a tick shifts out the next bit and the state does not change. When the counter is zero, a tick picks the next unit in this priority order:
- enable low → IDLE
- send-break high → BREAK
- coming from BREAK → MARK
- preamble pending → PREAMBLE
- holding register full → FRAME
- otherwise → IDLE

Top module: `uart_tx_brk`

## Requirements
- R1: While enabled with nothing left to send, tx_out is 1, tx_oe is 1 and tx_done is 1. tx_done is 1 only when the sequencer is in IDLE, the holding register is empty, no preamble is queued and no break is requested.
- R2: A frame is a start bit 0, then data bits 0..7 (0..8 when frame_long=1) least significant first, then a stop bit 1. tx_out changes only on the clock edge where bit_tick is 1.
- R3: A write made while the shifter is idle and enabled produces the start bit at the next tick. hold_empty returns to 1 at that same tick.
- R4: A write (wr_en=1 for one cycle) makes hold_empty 0 and tx_done 0 from the next cycle.
- R5: A byte written while a frame is shifting has its start bit directly after the previous stop bit, with no idle bit in between.
- R6: If tx_enable is cleared in the middle of a frame, the frame finishes unchanged and tx_oe stays 1. tx_oe falls at the tick that ends the stop bit.
- R7: While disabled, a byte in the holding register is not sent: tx_oe stays 0 and hold_empty stays 0.
- R8: Each 0→1 change of tx_enable queues a preamble of N ones, with N = 10, or 11 when frame_long=1. A pending byte starts directly after the preamble.
- R9: With send_break=1, the next unit boundary starts a break of N zero bits with no start or stop bit. A break request takes priority over a preamble and over data.
- R10: While send_break stays 1, breaks follow one another with no gap. After it is cleared, the break in progress completes and is followed by at least one 1 bit.
- R11: tx_oe is 1 exactly when tx_enable is 1 or the sequencer is not in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW+1 | Byte to send (top bit used only when frame_long=1) |
| tx_enable | input | 1 | Transmitter enable control bit |
| send_break | input | 1 | Send-break control bit |
| frame_long | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| hold_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmission complete flag |
| tx_out | output | 1 | Serial data output |
| tx_oe | output | 1 | Transmitter owns the pin |

## Verification
The bench checks these corner cases, and what a faulty design would show in each:
- **Disable in the middle of a frame.** A design that stops the shifter early would release the pin with the frame cut off. A design that ignores the held byte wrongly would send it with the pin already released.
- **Back-to-back writes and preamble followed by data.** A design with an off-by-one in the bit counter shows up as a spare idle bit or a missing stop bit.
- **A held break ended part-way through the second break character.** A design that cuts the break short, leaves a gap between breaks, or drops the trailing mark bit gives the wrong count of zeros, or a 0 where the 1 should be.
- **Random bytes in both frame lengths.** These catch bit-order and length errors.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PRE   = 3'd1,
        S_FRAME = 3'd2,
        S_BRK   = 3'd3,
        S_MARK  = 3'd4
    } tx_state_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW:0]   wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW:0]   data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_en) begin
                full <= 1'b1;
                data <= wr_data;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    // R4: a write always leaves the register full
    a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);
    // R3: a transfer without a concurrent write empties it
    a_r3_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !full);
endmodule

// File: rtl/uart_tx_preq.sv
module uart_tx_preq (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic taken,
    output logic pending
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            pending <= 1'b0;
        end else begin
            en_q <= enable;
            if (enable && !en_q)
                pending <= 1'b1;
            else if (taken)
                pending <= 1'b0;
        end
    end

    // R8: a rising enable always leaves a preamble queued
    a_r8_rise_queues: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> pending);
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        enable,
    input  logic        brk,
    input  logic        frame_long,
    input  logic        hold_full,
    input  logic [DW:0] hold_data,
    input  logic        pre_pend,
    output logic        take_data,
    output logic        take_pre,
    output logic        busy,
    output logic        tx_out
);
    localparam int LEN_S = DW + 2;
    localparam int LEN_L = DW + 3;
    localparam int SW    = DW + 2;
    localparam int CW    = $clog2(LEN_L);

    tx_state_t       state, nstate;
    logic [CW-1:0]   cnt, ncnt;
    logic [SW-1:0]   shreg, nsh;
    logic            tx_q, ntx;
    logic [CW-1:0]   last_cnt;
    logic [SW-1:0]   load_word;

    assign last_cnt  = frame_long ? CW'(LEN_L - 1) : CW'(LEN_S - 1);
    assign load_word = frame_long ? {1'b1, hold_data}
                                  : {2'b11, hold_data[DW-1:0]};

    always_comb begin
        nstate    = state;
        ncnt      = cnt;
        nsh       = shreg;
        ntx       = tx_q;
        take_data = 1'b0;
        take_pre  = 1'b0;
        if (tick) begin
            if (state != S_IDLE && cnt != '0) begin
                ntx  = shreg[0];
                nsh  = {1'b1, shreg[SW-1:1]};
                ncnt = cnt - 1'b1;
            end else begin
                ntx    = 1'b1;
                ncnt   = '0;
                nstate = S_IDLE;
                if (!enable) begin
                    nstate = S_IDLE;
                end else if (brk) begin
                    nstate = S_BRK;
                    ntx    = 1'b0;
                    nsh    = '0;
                    ncnt   = last_cnt;
                end else if (state == S_BRK) begin
                    nstate = S_MARK;
                end else if (pre_pend) begin
                    nstate   = S_PRE;
                    take_pre = 1'b1;
                    nsh      = '1;
                    ncnt     = last_cnt;
                end else if (hold_full) begin
                    nstate    = S_FRAME;
                    take_data = 1'b1;
                    ntx       = 1'b0;
                    nsh       = load_word;
                    ncnt      = last_cnt;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            shreg <= '1;
            tx_q  <= 1'b1;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
            shreg <= nsh;
            tx_q  <= ntx;
        end
    end

    always_comb begin
        unique case (state)
            S_IDLE:  busy = 1'b0;
            S_PRE, S_FRAME, S_BRK, S_MARK: busy = 1'b1;
            default: busy = 1'b1;
        endcase
    end

    assign tx_out = tx_q;

    // R1: the line marks whenever the sequencer is idle
    a_r1_idle_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> tx_q);
    // R2: no bit changes between ticks
    a_r2_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tx_q));
    // R6: a unit with bits left is never abandoned, whatever the enable does
    a_r6_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && cnt != '0 && tick) |=> (state == $past(state)));
    // R9: a break drives only zeros
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRK) |-> !tx_q);
    // R10: leaving a break always drives a one
    a_r10_mark_after: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_BRK && state != S_BRK) |-> tx_q);
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        wr_en,
    input  logic [DW:0] wr_data,
    input  logic        tx_enable,
    input  logic        send_break,
    input  logic        frame_long,
    output logic        hold_empty,
    output logic        tx_done,
    output logic        tx_out,
    output logic        tx_oe
);
    logic        full;
    logic [DW:0] hdata;
    logic        pre_pend;
    logic        take_data;
    logic        take_pre;
    logic        busy;

    uart_tx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take_data),
        .full    (full),
        .data    (hdata)
    );

    uart_tx_preq u_preq (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tx_enable),
        .taken   (take_pre),
        .pending (pre_pend)
    );

    uart_tx_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .enable     (tx_enable),
        .brk        (send_break),
        .frame_long (frame_long),
        .hold_full  (full),
        .hold_data  (hdata),
        .pre_pend   (pre_pend),
        .take_data  (take_data),
        .take_pre   (take_pre),
        .busy       (busy),
        .tx_out     (tx_out)
    );

    assign hold_empty = !full;
    assign tx_done    = !busy && !full && !pre_pend && !(send_break && tx_enable);
    assign tx_oe      = tx_enable || busy;

    // R7: with the pin released, a held byte stays held
    a_r7_held_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_oe && full) |=> full);
endmodule

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [DW:0] wr_data = '0;
    logic        tx_enable = 1'b0;
    logic        send_break = 1'b0;
    logic        frame_long = 1'b0;
    logic        hold_empty, tx_done, tx_out, tx_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_brk #(.DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_enable  (tx_enable),
        .send_break (send_break),
        .frame_long (frame_long),
        .hold_empty (hold_empty),
        .tx_done    (tx_done),
        .tx_out     (tx_out),
        .tx_oe      (tx_oe)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int flen(bit f9);
        return f9 ? DW + 3 : DW + 2;
    endfunction

    function automatic int exp_bit(logic [DW:0] d, bit f9, int idx);
        int nd = f9 ? DW + 1 : DW;
        if (idx == 0) return 0;
        if (idx <= nd) return int'(d[idx-1]);
        return 1;
    endfunction

    task automatic tick();
        int gap = $urandom_range(0, 2);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic write(logic [DW:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    // ticks through bits from_idx..last of a frame, checking each
    task automatic frame_bits(logic [DW:0] d, bit f9, int from_idx, string req);
        for (int i = from_idx; i < flen(f9); i++) begin
            tick();
            chk(req, $sformatf("frame bit %0d", i), int'(tx_out), exp_bit(d, f9, i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW:0] d, d2;
        bit f9;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1", "reset tx_out", int'(tx_out), 1);
        chk("R11", "reset tx_oe disabled", int'(tx_oe), 0);
        chk("R1", "reset hold_empty", int'(hold_empty), 1);
        chk("R1", "reset tx_done", int'(tx_done), 1);

        // enable: initial preamble
        tx_enable = 1'b1;
        @(negedge clk);
        chk("R11", "oe on enable", int'(tx_oe), 1);
        chk("R8", "done low with preamble queued", int'(tx_done), 0);
        for (int i = 0; i < flen(0); i++) begin
            tick();
            chk("R8", "preamble bit", int'(tx_out), 1);
        end
        tick();
        chk("R1", "idle done after preamble", int'(tx_done), 1);

        // random single frames
        for (int k = 0; k < 16; k++) begin
            f9 = bit'($urandom_range(0, 1));
            d = (DW+1)'($urandom);
            frame_long = f9;
            write(d);
            chk("R4", "hold_empty after write", int'(hold_empty), 0);
            chk("R4", "tx_done after write", int'(tx_done), 0);
            tick();
            chk("R3", "start bit", int'(tx_out), 0);
            chk("R3", "hold_empty at start", int'(hold_empty), 1);
            frame_bits(d, f9, 1, "R2");
            tick();
            chk("R1", "idle line", int'(tx_out), 1);
            chk("R1", "idle done", int'(tx_done), 1);
            chk("R1", "idle oe", int'(tx_oe), 1);
        end

        // back-to-back frames
        f9 = 1'b0; frame_long = 1'b0;
        d = 9'h0A5; d2 = 9'h03C;
        write(d);
        tick();
        chk("R3", "b2b first start", int'(tx_out), 0);
        write(d2);
        frame_bits(d, f9, 1, "R5");
        tick();
        chk("R5", "second start right after stop", int'(tx_out), 0);
        frame_bits(d2, f9, 1, "R5");
        tick();
        chk("R5", "idle after pair", int'(tx_done), 1);

        // disable mid-frame
        d = 9'h0F0; d2 = 9'h055;
        write(d);
        tick();
        frame_bits(d, f9, 1, "R2");  // runs whole frame; redo for mid-frame below
        tick();
        write(d);
        tick();
        tick();
        chk("R2", "bit1 before disable", int'(tx_out), exp_bit(d, f9, 1));
        tx_enable = 1'b0;
        @(negedge clk);
        chk("R6", "oe held while frame in flight", int'(tx_oe), 1);
        write(d2);
        frame_bits(d, f9, 2, "R6");
        chk("R6", "oe held through stop bit", int'(tx_oe), 1);
        tick();
        chk("R6", "oe released after frame", int'(tx_oe), 0);
        chk("R7", "pending byte kept", int'(hold_empty), 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7", "pin stays released", int'(tx_oe), 0);
            chk("R7", "byte not sent", int'(hold_empty), 0);
        end

        // re-enable: preamble then pending byte
        tx_enable = 1'b1;
        @(negedge clk);
        for (int i = 0; i < flen(f9); i++) begin
            tick();
            chk("R8", "re-enable preamble bit", int'(tx_out), 1);
            chk("R8", "byte still held during preamble", int'(hold_empty), 0);
        end
        tick();
        chk("R8", "start right after preamble", int'(tx_out), 0);
        frame_bits(d2, f9, 1, "R8");
        tick();
        chk("R1", "idle after preamble frame", int'(tx_done), 1);

        // break: two held, second ended part-way
        f9 = bit'($urandom_range(0, 1));
        frame_long = f9;
        send_break = 1'b1;
        @(negedge clk);
        chk("R9", "done low with break requested", int'(tx_done), 0);
        for (int i = 0; i < flen(f9) + 1; i++) begin
            tick();
            chk(i < flen(f9) ? "R9" : "R10", $sformatf("break bit %0d", i), int'(tx_out), 0);
        end
        send_break = 1'b0;
        for (int i = flen(f9) + 1; i < 2 * flen(f9); i++) begin
            tick();
            chk("R10", $sformatf("second break bit %0d", i), int'(tx_out), 0);
        end
        tick();
        chk("R10", "mark after break", int'(tx_out), 1);
        chk("R10", "busy during mark", int'(tx_done), 0);
        tick();
        chk("R1", "idle after break", int'(tx_done), 1);

        // break priority over queued data
        frame_long = 1'b0;
        write(9'h0FF);
        send_break = 1'b1;
        tick();
        chk("R9", "break wins over data", int'(tx_out), 0);
        send_break = 1'b0;
        for (int i = 1; i < flen(0); i++) tick();
        tick();
        chk("R10", "mark before data", int'(tx_out), 1);
        chk("R9", "data still held", int'(hold_empty), 0);
        tick();
        chk("R9", "data start after mark", int'(tx_out), 0);
        frame_bits(9'h0FF, 1'b0, 1, "R2");
        tick();
        chk("R1", "final idle", int'(tx_done), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule